// File: doc/BRIEF.md
# Matrix Row Rotator

This block turns a matrix of 8-bit unsigned elements into a copy in which every row is rotated left by its own row number. Row 0 stays as it is. Row 1 moves one place to the left. The last row moves by the number of rows minus one. Both matrices are kept in on-chip RAM, one element per word, at word address `row*COLS + column`.

A host fills the source RAM through a load port and then pulses `start`. A synchronous state machine then visits every element of every row, one element per clock. For each row it runs two column counters:

- The first counter covers the output columns that take a source element further right in the same row.
- The second counter fills the tail of the row with the leading source elements that wrap around.

A multiplexer selects which counter drives the source read address. Because the source read is registered, the destination write is delayed by one clock. When the run ends, `done` pulses for one clock and `cycles` holds the run length in clocks. The host then reads the result through a registered read port.

The row count must not exceed the column count, so that every row's rotation stays inside the row.

Top module: `mrot_top`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `cycles` is 0.
- R2: After a run, destination word `r*COLS + c` holds source word `r*COLS + ((c + r) mod COLS)` for every row r and column c.
- R3: Row 0 is copied to the destination unchanged.
- R4: In the last row (r = ROWS-1), the first ROWS-1 source elements land, in order, in the last ROWS-1 destination columns.
- R5: `busy` rises in the clock after a `start` is accepted in idle and stays high for exactly ROWS*(COLS+1)+1 clocks. `done` is a single-clock pulse in the first clock with `busy` low again.
- R6: When `done` is high, `cycles` equals ROWS*(COLS+1)+1, and `cycles` keeps that value while the block idles.
- R7: A `start` pulse while `busy` is high has no effect. The run length, the `done` pulse count and the result are unchanged.
- R8: A load write (`ld_en`) while `busy` is high is dropped, and the source RAM keeps its earlier contents.
- R9: `rd_data` shows the destination word at the `rd_addr` sampled on the previous clock edge.
- R10: A second run over new source data overwrites every destination word with the new rotated result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-clock pulse at the end of a run |
| cycles | output | CNTW | Clocks taken by the last run |
| ld_en | input | 1 | Source RAM write enable (ignored while busy) |
| ld_addr | input | AW | Source RAM write address |
| ld_data | input | DW | Source RAM write data |
| rd_addr | input | AW | Destination RAM read address |
| rd_data | output | DW | Destination RAM read data, one clock latency |

## Verification
The hardest cases to reach are requests that arrive in the middle of a run: a second `start` and a source load while the machine is busy. Neither leaves an obvious trace at the ports. The bench injects both a few clocks into a run. It then confirms that the run length and the `done` count are unchanged. Finally it starts a fresh run and compares the entire destination against the original data, so a load that slipped through would appear as a corrupted word.

// File: rtl/mrot_pkg.sv
package mrot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIRECT,
    ST_WRAP,
    ST_NEXT,
    ST_DONE
  } mrot_state_e;
endpackage

// File: rtl/mrot_ram.sv
module mrot_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 24,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mrot_fsm.sv
module mrot_fsm
  import mrot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        direct_last,
  input  logic        wrap_last,
  input  logic        row_zero,
  input  logic        row_last,
  output mrot_state_e state,
  output logic        go,
  output logic        busy,
  output logic        done
);
  mrot_state_e nxt;

  assign go = (state == ST_IDLE) && start;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_DIRECT;
      ST_DIRECT: if (direct_last) nxt = row_zero ? ST_NEXT : ST_WRAP;
      ST_WRAP:   if (wrap_last) nxt = ST_NEXT;
      ST_NEXT:   nxt = row_last ? ST_DONE : ST_DIRECT;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_DONE);
      if (go) busy <= 1'b1;
      else if (state == ST_DONE) busy <= 1'b0;
    end
  end

  // R5: done lasts a single clock
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: once working, the machine never falls straight back to idle
  assert_no_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_DONE) |=> state != ST_IDLE);
  // R5: busy tracks the non-idle machine
  assert_busy_match_R5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> busy);
endmodule

// File: rtl/mrot_addr_gen.sv
module mrot_addr_gen
  import mrot_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 6,
  parameter int AW   = 5,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  mrot_state_e   state,
  input  logic          go,
  output logic          direct_last,
  output logic          wrap_last,
  output logic          row_zero,
  output logic          row_last,
  output logic          issue,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
  localparam logic [CW-1:0] LAST_ROW = CW'(ROWS - 1);
  localparam logic [AW-1:0] ROW_STEP = AW'(COLS);

  logic [CW-1:0] row, kd, kw;
  logic [AW-1:0] base;
  logic [CW-1:0] src_col, dst_col;
  logic          in_wrap;

  assign row_zero    = (row == '0);
  assign row_last    = (row == LAST_ROW);
  assign direct_last = (kd == LAST_COL - row);
  assign wrap_last   = (kw == row - 1'b1);
  assign in_wrap     = (state == ST_WRAP);
  assign issue       = (state == ST_DIRECT) || in_wrap;

  // column multiplexer: direct counter or wrap counter
  always_comb begin
    if (in_wrap) begin
      src_col = row - kw - 1'b1;
      dst_col = LAST_COL - kw;
    end else begin
      src_col = row + kd;
      dst_col = kd;
    end
  end

  assign src_addr = base + AW'(src_col);
  assign dst_addr = base + AW'(dst_col);

  always_ff @(posedge clk) begin
    if (rst || go) begin
      row  <= '0;
      base <= '0;
      kd   <= '0;
      kw   <= '0;
    end else begin
      unique case (state)
        ST_DIRECT: if (!direct_last) kd <= kd + 1'b1;
        ST_WRAP:   if (!wrap_last) kw <= kw + 1'b1;
        ST_NEXT: begin
          kd <= '0;
          kw <= '0;
          if (!row_last) begin
            row  <= row + 1'b1;
            base <= base + ROW_STEP;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: reads stay inside the current row
  assert_src_in_row_R2: assert property (@(posedge clk) disable iff (rst)
    issue |-> (src_col <= LAST_COL));
  // R3: row 0 never enters the wrapping pass
  assert_row0_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    in_wrap |-> !row_zero);
  // R4: wrap pass writes descend from the last column
  assert_wrap_desc_R4: assert property (@(posedge clk) disable iff (rst)
    (in_wrap && !wrap_last) |=> (in_wrap && dst_col == $past(dst_col) - 1'b1));
endmodule

// File: rtl/mrot_top.sv
module mrot_top
  import mrot_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 6,
  parameter int DW   = 8,
  parameter int CNTW = 16,
  localparam int DEPTH = ROWS * COLS,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [CNTW-1:0] cycles,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW-1:0]   ld_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data
);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  mrot_state_e   state;
  logic          go, direct_last, wrap_last, row_zero, row_last, issue;
  logic [AW-1:0] src_addr, dst_addr, dst_addr_d;
  logic          wr_en_d;
  logic [DW-1:0] src_data;

  mrot_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .direct_last(direct_last), .wrap_last(wrap_last),
    .row_zero(row_zero), .row_last(row_last),
    .state(state), .go(go), .busy(busy), .done(done)
  );

  mrot_addr_gen #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .CW(CW)) u_agen (
    .clk(clk), .rst(rst), .state(state), .go(go),
    .direct_last(direct_last), .wrap_last(wrap_last),
    .row_zero(row_zero), .row_last(row_last),
    .issue(issue), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  mrot_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_src (
    .clk(clk), .we(ld_en && !busy), .waddr(ld_addr), .wdata(ld_data),
    .raddr(src_addr), .rdata(src_data)
  );

  mrot_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_dst (
    .clk(clk), .we(wr_en_d), .waddr(dst_addr_d), .wdata(src_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // write side trails the registered read by one clock
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_d    <= 1'b0;
      dst_addr_d <= '0;
    end else begin
      wr_en_d    <= issue;
      dst_addr_d <= dst_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || go) cycles <= '0;
    else if (state != ST_IDLE) cycles <= cycles + 1'b1;
  end

  // R6: count frozen while idle without a start
  assert_cycles_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> $stable(cycles));
  // R2: destination writes never land outside the matrix
  assert_dst_range_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en_d |-> (dst_addr_d < AW'(DEPTH)));
  // R5: the final write precedes the done pulse
  assert_drain_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en_d);
endmodule

// File: tb/sim_mrot_top.sv
module sim_mrot_top;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int DW = 8;
  localparam int CNTW = 16;
  localparam int DEPTH = ROWS * COLS;
  localparam int AW = $clog2(DEPTH);
  localparam int RUN_LEN = ROWS * (COLS + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done;
  logic [CNTW-1:0] cycles;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int busy_len = 0;

  always #4 clk = ~clk;

  mrot_top #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .CNTW(CNTW)) u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cycles(cycles), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(int seed, int r, int c);
    return DW'(seed * 37 + r * 16 + c * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_matrix(input int seed);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(r * COLS + c); ld_data = pat(seed, r, c);
      end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // pulse start; optionally inject start and a load mid-run
  task automatic run(input bit disturb);
    int n;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_seen = 0;
    busy_len = 0;
    n = 0;
    while (!done && n < 1000) begin
      if (busy) busy_len++;
      if (disturb && n == 5) begin start = 1'b1; ld_en = 1'b1; ld_addr = AW'(7); ld_data = 8'hEE; end
      if (disturb && n == 6) begin start = 1'b0; ld_en = 1'b0; end
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R5 done reached", done, 1);
    chk(busy == 1'b0, "R5 busy low at done", busy, 0);
    chk(busy_len == RUN_LEN, "R5 busy length", busy_len, RUN_LEN);
    chk(cycles == CNTW'(RUN_LEN), "R6 cycles at done", cycles, RUN_LEN);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(cycles == CNTW'(RUN_LEN), "R6 cycles held", cycles, RUN_LEN);
  endtask

  task automatic check_result(input int seed, input string tag);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rd_addr = AW'(r * COLS + c);
        @(negedge clk);
        chk(rd_data == pat(seed, r, (c + r) % COLS), tag, rd_data, pat(seed, r, (c + r) % COLS));
      end
  endtask

  task automatic test_reset;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(cycles == '0, "R1 cycles", cycles, 0);
  endtask

  task automatic test_basic;
    load_matrix(1);
    run(1'b0);
    check_result(1, "R2 rotation");
    for (int c = 0; c < COLS; c++) begin
      rd_addr = AW'(c);
      @(negedge clk);
      chk(rd_data == pat(1, 0, c), "R3 row0 identity", rd_data, pat(1, 0, c));
    end
    for (int j = 0; j < ROWS - 1; j++) begin
      rd_addr = AW'((ROWS - 1) * COLS + COLS - (ROWS - 1) + j);
      @(negedge clk);
      chk(rd_data == pat(1, ROWS - 1, j), "R4 last row wrap", rd_data, pat(1, ROWS - 1, j));
    end
  endtask

  task automatic test_latency;
    // R9: data follows address by exactly one edge
    rd_addr = AW'(2);
    @(negedge clk);
    rd_addr = AW'(COLS + 1);
    chk(rd_data == pat(1, 0, 2), "R9 read latency", rd_data, pat(1, 0, 2));
    @(negedge clk);
    chk(rd_data == pat(1, 1, 2), "R9 read latency next", rd_data, pat(1, 1, 2));
  endtask

  task automatic test_busy_ignore;
    load_matrix(5);
    run(1'b1);
    check_result(5, "R7 result after mid-run start");
    run(1'b0);
    check_result(5, "R8 load dropped while busy");
  endtask

  task automatic test_rerun;
    load_matrix(9);
    run(1'b0);
    check_result(9, "R10 rerun overwrite");
  endtask

  always @(posedge clk) if (done) done_seen++;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_latency();
    test_busy_ignore();
    test_rerun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule